// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock for an I2C master. A prescaler turns the fast source clock into a tick that fires once every `divider` source clocks. Each bus period is built from three tick counts taken from one 30-bit timing word: a low phase, a high phase and an overall cycle count. The low phase comes first and the high phase second. Any ticks left over until the cycle count is reached keep SCL low, which gives the bit engine a margin for changing SDA. When the low and high counts together are at least the cycle count, the period simply ends with the high phase.

SCL is driven in open-drain fashion. The block only requests a pull-down and watches the real line level through a two-flop synchronizer. While the line is released but still reads low, the block counts that as a target stretching the clock and freezes both the prescaler and the phase counter. Two single-cycle strobes show the bit engine when to act: one at the start of each low phase (change SDA now) and one halfway through the confirmed-high phase (sample SDA now). A new timing word or divider takes effect at the next period boundary. Dropping the enable releases the line and clears all counting at once.

Top module: `scl_timing_gen`

## Requirements
- R1: The timing word carries the high count in bits 29:20, the low count in bits 19:10 and the cycle count in bits 9:0. A tick occurs every `divider` source clocks, and a divider of 0 behaves as 1. For example, divider 7 with high 10, low 11 and cycle 26 gives a 184-clock period.
- R2: With a low count of at least 1, SCL is released exactly low×divider source clocks after the change strobe.
- R3: SCL stays released for high×divider + 2 source clocks, plus one clock for every clock that a target holds the line low after release.
- R4: The period is span×divider source clocks, where span = max(cycle, low+high, 1). When the high count is non-zero, add 2 plus the target's hold clocks. A high count of 0 keeps SCL low for the whole period.
- R5: `change_stb` pulses for one source clock at the start of each low phase, while SCL is still driven low, and once per period.
- R6: With a non-zero high count, `sample_stb` pulses once per period, 2 + hold + (high/2)×divider source clocks after the release, and only while the synchronized line reads high. With a high count of 0 it never pulses.
- R7: `stretch_det` is high exactly on the cycles where counting is paused: the high phase while the synchronized line reads low. That is 2 + hold cycles per period, and SCL remains released throughout.
- R8: While `enable` is low, SCL is released and both strobes stay low in the same cycle. After re-enable, `change_stb` is high in the first enabled cycle.
- R9: A timing word or divider that changes while enabled does not alter the running period. It governs the period that follows.
- R10: After reset with `enable` low, SCL is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock generator |
| divider | input | DIV_W | Source clocks per tick (0 behaves as 1) |
| timing_word | input | 3*CNT_W | High, low and cycle counts |
| scl_in | input | 1 | Observed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| change_stb | output | 1 | Start of low phase: SDA may change |
| sample_stb | output | 1 | Middle of high phase: sample SDA |
| stretch_det | output | 1 | Counting paused by a low line during high phase |

## Verification
A wrong prescaler or phase counter shows within one period as a release point, a high width or a period length that differs from the divider-scaled counts. A broken stretch path stretches every high phase by the wrong number of clocks, and the error is visible at the first release. A wrong latch of the configuration appears in the period right after a mid-period change, when the new counts arrive one period early. A bad enable path leaves SCL driven low in the very cycle the enable drops.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [DIV_W-1:0]   divider,
  input  logic [3*CNT_W-1:0] timing_word,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               change_stb,
  output logic               sample_stb,
  output logic               stretch_det
);
  localparam int POS_W = CNT_W + 1;

  logic [CNT_W-1:0] hi_q, lo_q, cyc_q;
  logic [DIV_W-1:0] div_q, pre_cnt;
  logic [POS_W-1:0] pos;
  logic             sync_a, sync_b;

  logic [DIV_W-1:0] pre_last;
  logic [POS_W-1:0] lo_ext, cyc_ext, hl_end, span_raw, span, mid;
  logic             in_high, stall, tick, wrap;

  assign pre_last = (div_q == '0) ? '0 : div_q - DIV_W'(1);
  assign lo_ext   = {1'b0, lo_q};
  assign cyc_ext  = {1'b0, cyc_q};
  assign hl_end   = lo_ext + {1'b0, hi_q};
  assign span_raw = (cyc_ext > hl_end) ? cyc_ext : hl_end;
  assign span     = (span_raw == '0) ? POS_W'(1) : span_raw;
  assign mid      = lo_ext + {2'b00, hi_q[CNT_W-1:1]};

  assign in_high = (pos >= lo_ext) && (pos < hl_end);
  assign stall   = enable && in_high && !sync_b;
  assign tick    = enable && !stall && (pre_cnt == pre_last);
  assign wrap    = tick && (pos == span - POS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b1;
      sync_b  <= 1'b1;
      hi_q    <= '0;
      lo_q    <= '0;
      cyc_q   <= '0;
      div_q   <= '0;
      pre_cnt <= '0;
      pos     <= '0;
    end else begin
      sync_a <= scl_in;
      sync_b <= sync_a;
      if (!enable || wrap) begin
        hi_q  <= timing_word[3*CNT_W-1:2*CNT_W];
        lo_q  <= timing_word[2*CNT_W-1:CNT_W];
        cyc_q <= timing_word[CNT_W-1:0];
        div_q <= divider;
      end
      if (!enable) begin
        pre_cnt <= '0;
        pos     <= '0;
      end else if (!stall) begin
        if (tick) begin
          pre_cnt <= '0;
          pos     <= wrap ? '0 : pos + POS_W'(1);
        end else begin
          pre_cnt <= pre_cnt + DIV_W'(1);
        end
      end
    end
  end

  assign scl_drive_low = enable && !in_high;
  assign change_stb    = enable && !stall && (pos == '0) && (pre_cnt == '0);
  assign sample_stb    = enable && in_high && sync_b && (pos == mid) && (pre_cnt == '0);
  assign stretch_det   = stall;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic change_stb,
  input logic sample_stb,
  input logic stretch_det
);
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!scl_drive_low && !change_stb && !sample_stb)); // R8
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_drive_low); // R6
  AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(scl_in, 2)); // R6
  AST_STRETCH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_det |-> !scl_drive_low); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_det |=> !scl_drive_low); // R7
endmodule

bind scl_timing_gen scl_timing_chk i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .change_stb(change_stb),
  .sample_stb(sample_stb), .stretch_det(stretch_det)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divider = '0;
  logic [29:0] timing_word = '0;
  logic        tgt_hold = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, change_stb, sample_stb, stretch_det;

  int n_chk = 0;
  int n_fail = 0;
  int hold_len = 0;
  int hctr = 0;
  bit pend = 0;
  logic [7:0]  pend_div;
  logic [29:0] pend_word;
  int m_rel, m_hi, m_per, m_soff, m_scnt, m_sst, m_drv0;

  assign scl_in = ~scl_drive_low & ~tgt_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divider(divider),
    .timing_word(timing_word), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .change_stb(change_stb), .sample_stb(sample_stb), .stretch_det(stretch_det)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (scl_drive_low) begin
      hctr = 0;
      tgt_hold = (hold_len > 0);
    end else begin
      hctr++;
      tgt_hold = (hctr <= hold_len);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int exp_period(input int d, input int h, input int l, input int c, input int hold);
    int span;
    span = (c > l + h) ? c : l + h;
    if (span == 0) span = 1;
    return span * eff_div(d) + ((h > 0) ? 2 + hold : 0);
  endfunction

  task automatic start_cfg(input int d, input int h, input int l, input int c);
    enable = 1'b0;
    divider = 8'(d);
    timing_word = {10'(h), 10'(l), 10'(c)};
    repeat (3) step();
    enable = 1'b1;
  endtask

  task automatic meas();
    int t;
    int back;
    int guard;
    guard = 0;
    while (!change_stb && guard < 5000) begin
      step();
      guard++;
    end
    m_rel = -1; back = -1; m_soff = -1; m_scnt = 0; m_sst = 0;
    m_drv0 = scl_drive_low ? 1 : 0;
    t = 0;
    forever begin
      if (!scl_drive_low && m_rel < 0) m_rel = t;
      if (m_rel >= 0 && scl_drive_low && back < 0) back = t;
      if (sample_stb) begin
        m_scnt++;
        m_soff = t - m_rel;
      end
      if (stretch_det) m_sst++;
      if (t == 1 && pend) begin
        divider = pend_div;
        timing_word = pend_word;
        pend = 0;
      end
      step();
      t++;
      if (change_stb || t > 5000) break;
    end
    m_per = t;
    if (m_rel >= 0 && back < 0) back = t;
    m_hi = (m_rel >= 0) ? back - m_rel : -1;
  endtask

  task automatic check_period(input string tag, input int d, input int h, input int l,
                              input int c, input int hold);
    int de;
    de = eff_div(d);
    hold_len = hold;
    meas();
    chk({tag, " R4 period"}, m_per, exp_period(d, h, l, c, hold));
    chk({tag, " R5 change while low"}, m_drv0, 1);
    if (h > 0) begin
      chk({tag, " R2 release"}, m_rel, l * de);
      chk({tag, " R3 high width"}, m_hi, 2 + hold + h * de);
      chk({tag, " R6 sample offset"}, m_soff, 2 + hold + (h / 2) * de);
      chk({tag, " R6 sample count"}, m_scnt, 1);
      chk({tag, " R7 stretch cycles"}, m_sst, 2 + hold);
    end else begin
      chk({tag, " R4 never released"}, m_rel, -1);
      chk({tag, " R6 no sample"}, m_scnt, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R10 drive", int'(scl_drive_low), 0);
    chk("R10 change", int'(change_stb), 0);
    chk("R10 sample", int'(sample_stb), 0);

    start_cfg(7, 10, 11, 26);
    check_period("R1 slow", 7, 10, 11, 26, 0);
    start_cfg(2, 5, 12, 24);
    check_period("R1 fast", 2, 5, 12, 24, 0);
    start_cfg(1, 3, 9, 18);
    check_period("R1 fastest", 1, 3, 9, 18, 0);
    start_cfg(0, 3, 4, 9);
    check_period("R1 zero divider", 0, 3, 4, 9, 0);
    start_cfg(3, 6, 4, 8);
    check_period("R4 cycle below sum", 3, 6, 4, 8, 0);
    start_cfg(2, 0, 3, 7);
    check_period("R4 no high", 2, 0, 3, 7, 0);
    start_cfg(2, 4, 3, 12);
    check_period("R7 stretch", 2, 4, 3, 12, 5);

    start_cfg(2, 4, 5, 20);
    check_period("R9 warmup", 2, 4, 5, 20, 0);
    pend_div = 8'd1;
    pend_word = {10'd3, 10'd3, 10'd10};
    pend = 1;
    check_period("R9 old period", 2, 4, 5, 20, 0);
    check_period("R9 new period", 1, 3, 3, 10, 0);

    start_cfg(3, 5, 4, 20);
    while (scl_drive_low) step();
    step();
    enable = 1'b0;
    #1;
    chk("R8 drive off in high", int'(scl_drive_low), 0);
    start_cfg(3, 5, 4, 20);
    step(); step();
    enable = 1'b0;
    #1;
    chk("R8 drive off in low", int'(scl_drive_low), 0);
    chk("R8 change off", int'(change_stb), 0);
    chk("R8 sample off", int'(sample_stb), 0);
    step();
    chk("R8 stays released", int'(scl_drive_low), 0);
    enable = 1'b1;
    #1;
    chk("R8 change at restart", int'(change_stb), 1);
    check_period("R8 after restart", 3, 5, 4, 20, 0);

    for (int i = 0; i < 30; i++) begin
      int d, h, l, c, hold;
      d = 1 + int'($urandom % 4);
      h = ($urandom % 6 == 0) ? 0 : 1 + int'($urandom % 10);
      l = 1 + int'($urandom % 12);
      c = int'($urandom % 31);
      hold = int'($urandom % 6);
      start_cfg(d, h, l, c);
      check_period("rand R2", d, h, l, c, hold);
      check_period("rand R3", d, h, l, c, hold);
    end

    hold_len = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule